// File: doc/BRIEF.md
# Overlapping 1101 Serial Pattern Detector

This block watches a serial bit stream, taking one bit on each rising clock edge. It raises a flag in the same cycle that the bit completing the sequence 1,1,0,1 is presented. The flag is a Mealy output: it is decoded from the current state and the live input bit, so it is valid before the clock edge that consumes that bit. Matches may overlap. The final 1 of one match also counts as the first 1 of the next match.

Progress through the pattern is held in a four-state machine stored in two flip-flops with Gray-code assignment. The encodings are idle=00, one=01, one-one=11 and one-one-zero=10, with the upper bit first. A synchronous, active-high reset returns the machine to idle. A designer places the block directly on a serial data line and uses the flag as a one-cycle strobe.

Top module: `seq_match_1101`

## Requirements
- R1: When `rst` is high at a rising edge, the machine returns to idle. After that edge, `hit` stays 0 even when `din`=1, and a partial match in progress before the reset does not count toward a later match.
- R2: `hit` is 1 in the cycle in which `din`=1 is presented after the three preceding bits accepted since reset were 1,1,0.
- R3: Overlapping matches are reported. After a match, the bits 1,0,1 alone complete another match, so the stream 1101101 gives `hit` on the 4th and 7th bits.
- R4: `hit` is 0 in every cycle that does not meet R2, including cycles in which fewer than four bits have been accepted since reset.
- R5: A run of extra 1s before the 0 keeps progress at the one-one state. For the stream 11101, `hit` is raised on the 5th bit only.
- R6: A 0 that follows 1,1,0 clears all progress. For the stream 11001101, `hit` is raised on the 8th bit only.
- R7: A 0 that follows a single 1 clears progress. For the stream 101101, `hit` is raised on the 6th bit only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state advances on the rising edge |
| rst | input | 1 | Synchronous active-high reset to the idle state |
| din | input | 1 | Serial data bit, sampled at each rising edge |
| hit | output | 1 | Combinational match flag for the bit currently on `din` |

## Verification
The bench drives these streams:
- A plain 1101, which confirms a basic match.
- 1101101, which confirms that an overlapping match keeps the trailing 1.
- 11101, which separates a design that holds at one-one on a repeated 1 from one that falls back.
- 11001101, which shows that a second 0 after 1,1,0 clears progress.
- 101101, which shows that a 0 after a lone 1 clears progress.

A reset placed in the middle of a partial match, followed by a 1, shows that reset discards progress. Long stretches of all ones and all zeros, together with an alternating stream, confirm that no false flag appears.

// File: rtl/seq_match_pkg.sv
package seq_match_pkg;

    // Gray-coded progress states: upper bit is the first flop
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,   // no useful prefix
        ST_ONE  = 2'b01,   // saw 1
        ST_ONE2 = 2'b11,   // saw 1,1
        ST_OOZ  = 2'b10    // saw 1,1,0
    } prog_t;

    localparam prog_t RESET_STATE = ST_IDLE;

    function automatic prog_t step(input prog_t cur, input logic bit_in);
        prog_t nxt;
        unique case (cur)
            ST_IDLE: nxt = bit_in ? ST_ONE  : ST_IDLE;
            ST_ONE:  nxt = bit_in ? ST_ONE2 : ST_IDLE;
            ST_ONE2: nxt = bit_in ? ST_ONE2 : ST_OOZ;
            ST_OOZ:  nxt = bit_in ? ST_ONE  : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
        return nxt;
    endfunction

    function automatic logic completes(input prog_t cur, input logic bit_in);
        return (cur == ST_OOZ) && bit_in;
    endfunction

endpackage

// File: rtl/seq_match_next.sv
module seq_match_next
    import seq_match_pkg::*;
(
    input  prog_t cur_st,
    input  logic  bit_in,
    output prog_t nxt_st
);
    always_comb begin
        nxt_st = step(cur_st, bit_in);
    end
endmodule

// File: rtl/seq_match_reg.sv
module seq_match_reg
    import seq_match_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  prog_t d_st,
    output prog_t q_st
);
    always_ff @(posedge clk) begin
        if (rst) q_st <= RESET_STATE;
        else     q_st <= d_st;
    end
endmodule

// File: rtl/seq_match_out.sv
module seq_match_out
    import seq_match_pkg::*;
(
    input  prog_t cur_st,
    input  logic  bit_in,
    output logic  flag
);
    always_comb begin
        flag = completes(cur_st, bit_in);
    end
endmodule

// File: rtl/seq_match_1101.sv
module seq_match_1101
    import seq_match_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic hit
);
    prog_t st_q;
    prog_t st_d;

    seq_match_next u_next (
        .cur_st (st_q),
        .bit_in (din),
        .nxt_st (st_d)
    );

    seq_match_reg u_reg (
        .clk  (clk),
        .rst  (rst),
        .d_st (st_d),
        .q_st (st_q)
    );

    seq_match_out u_out (
        .cur_st (st_q),
        .bit_in (din),
        .flag   (hit)
    );

    // R1: reset lands in idle
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (st_q == ST_IDLE));

    // R2/R4: flag only with a live 1 after 1,1,0
    assert_hit_needs_din_R2: assert property (@(posedge clk) disable iff (rst)
        hit |-> (din && st_q == ST_OOZ));

    // R3: a match leaves the machine holding one 1
    assert_overlap_keep_R3: assert property (@(posedge clk) disable iff (rst)
        hit |=> (st_q == ST_ONE));

    // R5: repeated 1 holds at one-one
    assert_ones_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ONE2 && din) |=> (st_q == ST_ONE2));

    // R6: 0 after 1,1,0 clears progress
    assert_ooz_zero_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_OOZ && !din) |=> (st_q == ST_IDLE));

    // R7: 0 after a lone 1 clears progress
    assert_one_zero_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ONE && !din) |=> (st_q == ST_IDLE));
endmodule

// File: tb/sim_seq_match_1101.sv
module sim_seq_match_1101;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic hit;

    int n_chk  = 0;
    int n_fail = 0;

    logic  exp_q[$];
    string tag_q[$];
    logic  [2:0] hist;
    int    seen;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    seq_match_1101 u0 (.clk(clk), .rst(rst), .din(din), .hit(hit));

    // driver: present one bit, predict flag from last bits since reset
    task automatic send(input logic b, input string tag);
        @(negedge clk);
        din = b;
        #1;
        exp_q.push_back((seen >= 3) && ({hist, b} == 4'b1101));
        tag_q.push_back(tag);
        hist = {hist[1:0], b};
        seen++;
    endtask

    task automatic send_str(input string s, input string tag);
        for (int i = 0; i < s.len(); i++) send(s[i] == "1", tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        din = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        hist = 3'b000;
        seen = 0;
    endtask

    // monitor: compare after the driver has settled each bit
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() > 0) begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (hit !== e) begin
                    n_fail++;
                    $display("FAIL %s: hit=%b expected %b at %0t", t, hit, e, $time);
                end
            end
        end
    end

    initial begin
        hist = 3'b000;
        seen = 0;
        do_reset();
        send(1'b1, "R1");                    // idle after reset: no flag
        do_reset();
        send_str("1101", "R2");
        do_reset();
        send_str("1101101", "R3");
        do_reset();
        send_str("11101", "R5");
        do_reset();
        send_str("11001101", "R6");
        do_reset();
        send_str("101101", "R7");
        do_reset();
        send_str("11111111", "R4");
        send_str("00000000", "R4");
        send_str("10101010", "R4");
        send_str("1101101101", "R3");
        do_reset();
        send_str("110", "R1");               // partial match, then reset
        do_reset();
        send(1'b1, "R1");
        send_str("1101", "R2");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule